// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

When a master is reset in the middle of a transfer, a slave can be left holding SDA low, waiting for clocks that will never come. No master may begin a transfer while the bus looks busy, so the bus stays locked. This block breaks that deadlock. After reset, and again each time it receives a start strobe, it samples both bus lines. If SDA is low, it pulls SCL low and releases it repeatedly through open-drain drive enables, leaving SDA untouched, until the slave lets go of SDA. It then generates a STOP condition and hands the bus back idle.

Each recovery clock has a low half and a high half, and each half lasts at least a parameter number of system clock cycles. The high half is only timed once SCL actually reads high, so another master stretching the clock is respected. The block stops clocking as soon as SDA is seen high and never issues more than nine clocks. It reports failure if SDA never comes free or if SCL is held low beyond a timeout. Both bus inputs pass through two-flop synchronizers, and the outputs can only pull a line low.

Top module: `i2c_bus_rescue`

## Requirements
- R1: Immediately after reset the block drives neither line low, busy is 1 and done is 0, because a bus check starts on its own.
- R2: If both lines read high when checked, the block finishes with done=1 and fail=0 and never drives either line low during that check.
- R3: The block never drives SDA low while recovery clocks are being issued. In a successful recovery, SDA is pulled low exactly once, after the last recovery clock, and never in a failed one.
- R4: If the slave frees SDA on its Nth SCL falling edge, for N from 1 to 9, exactly N recovery clocks (rising edges of scl_drive_low) are issued and fail=0.
- R5: If SDA stays low, exactly 9 recovery clocks are issued. The block then ends with done=1 and fail=1 and releases both lines.
- R6: Every SCL low phase driven by the block lasts at least HALF_CYC cycles. SCL reads high for at least HALF_CYC cycles before each further recovery clock.
- R7: When another device holds SCL low after a release, the next clock waits until SCL has read high for at least HALF_CYC cycles, and the clock count is unchanged.
- R8: If SCL stays low for STRETCH_LIMIT cycles while the block waits for it to rise, the block ends with done=1 and fail=1 and releases both lines.
- R9: The STOP pulls SDA low only while SCL is driven low. It then releases SDA while SCL is high, which gives exactly one SDA rising edge with SCL high.
- R10: busy is 1 from an accepted start until done. A start strobe while busy is ignored. done and fail hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run a bus check and recovery |
| scl_i | input | 1 | Sampled SCL bus level (asynchronous) |
| sda_i | input | 1 | Sampled SDA bus level (asynchronous) |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A check or recovery is in progress |
| done | output | 1 | The last run has finished |
| fail | output | 1 | The last run ended without freeing the bus (valid with done) |

## Verification
The bench models a wired-AND bus with a stuck slave that releases SDA on its Nth SCL falling edge. It sweeps N from 0 to 11, which separates the idle bus (no clocks at all), early release at each count up to nine, and the never-released case that must hit the cap and fail. The same sweep is repeated with a second device stretching every SCL low phase by a few cycles. This shows that the clock count does not change under stretching while the measured high time still meets the half period. Stretches longer than the timeout, and SCL held low throughout the check, tell the two abort points apart by their clock counts. A start strobe injected mid-run shows it neither restarts nor extends the recovery.

// File: rtl/i2crec_pkg.sv
package i2crec_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHK,
        ST_CHK_WAIT,
        ST_P_LO,
        ST_P_RISE,
        ST_P_HI,
        ST_S_SCL,
        ST_S_SDA,
        ST_S_RISE,
        ST_S_HI,
        ST_S_END
    } rec_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

    // Which lines are pulled low in a given state.
    function automatic line_pair_t pull_for(rec_state_e s);
        line_pair_t p;
        p.scl = (s == ST_P_LO) || (s == ST_S_SCL) || (s == ST_S_SDA);
        p.sda = (s == ST_S_SDA) || (s == ST_S_RISE) || (s == ST_S_HI);
        return p;
    endfunction

endpackage

// File: rtl/i2crec_sync.sv
module i2crec_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d[b]};
            end
            assign q[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2crec_timer.sv
module i2crec_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [TW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)   cnt <= '0;
        else if (~&cnt)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_bus_rescue.sv
module i2c_bus_rescue
    import i2crec_pkg::*;
#(
    parameter int HALF_CYC      = 1250,
    parameter int STRETCH_LIMIT = 25000,
    parameter int MAX_PULSES    = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_drive_low,
    output logic sda_drive_low,
    output logic busy,
    output logic done,
    output logic fail
);
    localparam int TMAX = (HALF_CYC > STRETCH_LIMIT) ? HALF_CYC : STRETCH_LIMIT;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PW   = $clog2(MAX_PULSES + 1);

    rec_state_e    state_q, state_d;
    line_pair_t    raw, seen, pull;
    logic [TW-1:0] tmr;
    logic [PW-1:0] pulse_q;
    logic          half_up, stretch_up, pulse_inc, fin_ok, fin_bad, accept;
    logic          done_q, fail_q;

    assign raw = '{scl: scl_i, sda: sda_i};

    // Both bus inputs are synchronized before any decision.
    i2crec_sync #(.W(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (seen)
    );

    // Phase timer restarts on every state change.
    i2crec_timer #(.TW(TW)) u_tmr (
        .clk (clk),
        .rst (rst),
        .clr (state_d != state_q),
        .cnt (tmr)
    );

    assign half_up    = (tmr == TW'(HALF_CYC - 1));
    assign stretch_up = (tmr == TW'(STRETCH_LIMIT - 1));
    assign accept     = (state_q == ST_IDLE) && start_i;

    always_comb begin
        state_d   = state_q;
        pulse_inc = 1'b0;
        fin_ok    = 1'b0;
        fin_bad   = 1'b0;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_CHK;
            ST_CHK:      if (half_up) state_d = ST_CHK_WAIT;
            ST_CHK_WAIT: begin
                if (seen.scl) begin
                    if (seen.sda) begin state_d = ST_IDLE; fin_ok = 1'b1; end
                    else          state_d = ST_P_LO;
                end else if (stretch_up) begin
                    state_d = ST_IDLE; fin_bad = 1'b1;
                end
            end
            ST_P_LO: if (half_up) begin
                pulse_inc = 1'b1;
                state_d   = seen.sda ? ST_S_SDA : ST_P_RISE;
            end
            ST_P_RISE: begin
                if (seen.scl)        state_d = ST_P_HI;
                else if (stretch_up) begin state_d = ST_IDLE; fin_bad = 1'b1; end
            end
            ST_P_HI: begin
                if (seen.sda) state_d = ST_S_SCL;
                else if (half_up) begin
                    if (pulse_q == PW'(MAX_PULSES)) begin
                        state_d = ST_IDLE; fin_bad = 1'b1;
                    end else begin
                        state_d = ST_P_LO;
                    end
                end
            end
            ST_S_SCL: if (half_up) state_d = ST_S_SDA;
            ST_S_SDA: if (half_up) state_d = ST_S_RISE;
            ST_S_RISE: begin
                if (seen.scl)        state_d = ST_S_HI;
                else if (stretch_up) begin state_d = ST_IDLE; fin_bad = 1'b1; end
            end
            ST_S_HI:  if (half_up) state_d = ST_S_END;
            ST_S_END: if (half_up) begin state_d = ST_IDLE; fin_ok = 1'b1; end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CHK;
            pulse_q <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept)         pulse_q <= '0;
            else if (pulse_inc) pulse_q <= pulse_q + 1'b1;
            if (accept) begin
                done_q <= 1'b0;
                fail_q <= 1'b0;
            end else if (fin_ok || fin_bad) begin
                done_q <= 1'b1;
                fail_q <= fin_bad;
            end
        end
    end

    assign pull          = pull_for(state_q);
    assign scl_drive_low = pull.scl;
    assign sda_drive_low = pull.sda;
    assign busy          = (state_q != ST_IDLE);
    assign done          = done_q;
    assign fail          = fail_q;

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!scl_drive_low && !sda_drive_low && busy));

    a_r5_pulse_cap: assert property (@(posedge clk) disable iff (rst)
        pulse_q <= PW'(MAX_PULSES));

    a_r8_fail_releases: assert property (@(posedge clk) disable iff (rst)
        fail |-> (!scl_drive_low && !sda_drive_low && done));

    a_r9_sda_under_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> scl_drive_low);

    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: tb/sim_i2c_bus_rescue.sv
module sim_i2c_bus_rescue;
    localparam int HALF = 5;
    localparam int SLIM = 40;
    localparam int MAXP = 9;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, start;
    logic scl_dl, sda_dl, busy, done, fail;
    logic scl_line, sda_line;

    int   need = 0;
    int   hold_len = 0;
    logic hold_forever = 1'b0;
    logic mon_clr = 1'b0;

    int   falls, hold_cnt, pulses, lo_run, hi_run, lo_bad, hi_bad;
    int   sda_rises, stops, done_rises, drives, order_bad;
    logic sda_seen, prev_scl_line, prev_sda_line, prev_scl_dl, prev_sda_dl, prev_done;

    int n_chk = 0;
    int n_err = 0;

    assign scl_line = !(scl_dl || (hold_cnt > 0) || hold_forever);
    assign sda_line = !(sda_dl || (falls < need));

    i2c_bus_rescue #(.HALF_CYC(HALF), .STRETCH_LIMIT(SLIM), .MAX_PULSES(MAXP)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .scl_i(scl_line), .sda_i(sda_line),
        .scl_drive_low(scl_dl), .sda_drive_low(sda_dl),
        .busy(busy), .done(done), .fail(fail)
    );

    // Bus monitor and stuck-slave / stretching-master model.
    always @(negedge clk) begin
        if (mon_clr) begin
            falls <= 0; hold_cnt <= 0; pulses <= 0; lo_run <= 0; hi_run <= 0;
            lo_bad <= 0; hi_bad <= 0; sda_rises <= 0; stops <= 0; done_rises <= 0;
            drives <= 0; order_bad <= 0; sda_seen <= 1'b0;
        end else begin
            if (prev_scl_line && !scl_line) falls <= falls + 1;
            if (scl_dl && !prev_scl_dl) begin
                pulses <= pulses + 1;
                if (pulses > 0 && hi_run < HALF) hi_bad <= hi_bad + 1;
                if (sda_seen) order_bad <= order_bad + 1;
                hold_cnt <= hold_len;
            end else if (!scl_dl && hold_cnt > 0) begin
                hold_cnt <= hold_cnt - 1;
            end
            lo_run <= scl_dl ? lo_run + 1 : 0;
            if (!scl_dl && prev_scl_dl && lo_run < HALF) lo_bad <= lo_bad + 1;
            hi_run <= scl_line ? hi_run + 1 : 0;
            if (sda_dl && !prev_sda_dl) begin
                sda_rises <= sda_rises + 1;
                sda_seen  <= 1'b1;
            end
            if (sda_line && !prev_sda_line && scl_line && prev_scl_line) stops <= stops + 1;
            if (done && !prev_done) done_rises <= done_rises + 1;
            if (scl_dl || sda_dl) drives <= drives + 1;
        end
        prev_scl_line <= scl_line;
        prev_sda_line <= sda_line;
        prev_scl_dl   <= scl_dl;
        prev_sda_dl   <= sda_dl;
        prev_done     <= done;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_done(input int poke_at);
        int k;
        k = 0;
        while (!done && k < 4000) begin
            @(negedge clk);
            #1;
            start = (poke_at > 0 && k == poke_at);
            k++;
        end
        start = 1'b0;
        chk(done, "R10 finish within limit", done, 1);
    endtask

    task automatic run_case(input int n, input int hl, input bit hard_hold,
                            input bit exp_fail, input int exp_p, input int poke_at);
        @(negedge clk); #1;
        need = n; hold_len = hl; hold_forever = hard_hold; mon_clr = 1'b1;
        @(negedge clk); #1;
        mon_clr = 1'b0; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        chk(busy && !done, "R10 busy after start", busy, 1);
        wait_done(poke_at);
        @(negedge clk);
        chk(fail == exp_fail, exp_fail ? "R5/R8 fail flag" : "R4 fail flag", fail, exp_fail);
        chk(pulses == exp_p, exp_fail ? "R5 clock count" : "R4 clock count", pulses, exp_p);
        chk(lo_bad == 0, "R6 low phase length", lo_bad, 0);
        chk(hi_bad == 0, hl > 0 ? "R7 high after stretch" : "R6 high phase length", hi_bad, 0);
        chk(done_rises == 1, "R10 single completion", done_rises, 1);
        chk(!scl_dl && !sda_dl, "R8 lines released at end", scl_dl + sda_dl, 0);
        if (exp_fail) begin
            chk(sda_rises == 0, "R3 no SDA drive in failure", sda_rises, 0);
        end else if (n == 0) begin
            chk(drives == 0, "R2 idle bus untouched", drives, 0);
        end else begin
            chk(sda_rises == 1, "R3 SDA pulled once", sda_rises, 1);
            chk(order_bad == 0, "R3 SDA untouched while clocking", order_bad, 0);
            chk(stops == 1, "R9 one STOP edge", stops, 1);
        end
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; mon_clr = 1'b1;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0; mon_clr = 1'b0;
        @(negedge clk);
        // R1: automatic check right after reset
        chk(busy && !done && !fail, "R1 busy after reset", {busy, done, fail}, 3'b100);
        chk(!scl_dl && !sda_dl, "R1 lines released after reset", scl_dl + sda_dl, 0);
        wait_done(0);
        @(negedge clk);
        chk(!fail && drives == 0, "R2 idle bus at reset check", fail + drives, 0);

        for (int n = 0; n <= 11; n++)
            run_case(n, 0, 1'b0, n > MAXP, (n > MAXP) ? MAXP : n, 0);
        for (int n = 1; n <= MAXP; n++) run_case(n, 3, 1'b0, 1'b0, n, 0);
        for (int n = 1; n <= MAXP; n++) run_case(n, 9, 1'b0, 1'b0, n, 0);

        // R8: stretch beyond limit after first clock, and SCL stuck during check
        run_case(3, 60, 1'b0, 1'b1, 1, 0);
        run_case(2, 0, 1'b1, 1'b1, 0, 0);
        hold_forever = 1'b0;

        // R10: done and fail persist until the next start
        run_case(12, 0, 1'b0, 1'b1, MAXP, 0);
        repeat (20) @(negedge clk);
        chk(done && fail, "R10 status held", {done, fail}, 2'b11);

        // R10: start while busy is ignored
        run_case(5, 0, 1'b0, 1'b0, 5, 25);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    int wd = 0;
    always @(negedge clk) begin
        wd <= wd + 1;
        if (wd > 190000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 190000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule